// File: doc/BRIEF.md
# Parallel Memory Bus Slave Front End

This block sits between the pins of an asynchronous parallel memory bus and the synchronous logic of a flash-style memory. The bus has three active-low controls: chip enable, output enable and write enable. A fast system clock samples all of them. The block recognises read cycles and drives the data lines, or releases them, from a word-wide array port. It turns each write cycle into one address/data record for a downstream command interpreter.

A write cycle may be framed by write enable with chip enable held low, or by chip enable with write enable held low. The address is taken where the later of the two controls falls. The data is taken where the earlier of the two rises. A width-select pin picks word mode (16 active lines) or byte mode. In byte mode only the low eight lines carry data, and the top data line supplies the byte-select address bit.

Captured writes leave the block on a one-cycle strobe with no back-pressure. The consumer must accept a record in the cycle it appears, and the payload holds its value until the next capture. Write cycles that begin, or continue, with output enable low are not captured. Each one is reported on a separate one-cycle discard pulse.

Top module: `pbus_front`

## Requirements
- R1: With chip enable low, output enable low and write enable high in word mode, all 16 lines are driven (`bus_dq_oe` = 16'hFFFF) with the array word at `bus_addr`. With write enable low, nothing is driven.
- R2: Whenever chip enable or output enable is high, `bus_dq_oe` is all zeros.
- R3: In byte mode (`bus_wide` = 0), a read drives only lines 0 to 7 (`bus_dq_oe` = 16'h00FF). Those lines carry array bits 15:8 when `bus_dq_i[15]` = 1 and bits 7:0 when it is 0. The array is always addressed with the word address.
- R4: A write-enable low pulse while chip enable is held low and output enable is high produces exactly one capture record.
- R5: A chip-enable low pulse while write enable is held low and output enable is high produces exactly one capture record.
- R6: The captured address is the one present when the later of chip enable and write enable falls. Address changes before or after that point do not affect it.
- R7: The captured data is the value on `bus_dq_i[7:0]` when the first of chip enable and write enable rises. The second rise creates no further record.
- R8: `wr_data` takes only `bus_dq_i[7:0]`. `wr_byte` is the inverse of `bus_wide` at address capture. In byte mode `wr_lsb` equals `bus_dq_i[15]` at address capture; in word mode it is 0.
- R9: A write cycle whose start finds output enable low yields no record and exactly one `wr_drop` pulse.
- R10: If output enable goes low during a captured write, that write yields no record and exactly one `wr_drop` pulse.
- R11: `wr_valid` is never high in two consecutive cycles. It is never high in the same cycle as `wr_drop`.
- R12: `wr_valid` rises no later than 4 clock cycles after the pin edge that ends the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable pin, active low, asynchronous |
| bus_we_n | input | 1 | Write enable pin, active low, asynchronous |
| bus_wide | input | 1 | Width select: 1 word mode, 0 byte mode |
| bus_addr | input | AW | Word address pins |
| bus_dq_i | input | DW | Data lines as seen at the pins |
| bus_dq_o | output | DW | Data line output values |
| bus_dq_oe | output | DW | Per-line output enable, 1 drives the line |
| arr_addr | output | AW | Word address to the array read port |
| arr_data | input | DW | Array word for `arr_addr`, combinational |
| wr_valid | output | 1 | One-cycle strobe for a captured write |
| wr_addr | output | AW | Captured word address |
| wr_lsb | output | 1 | Captured byte-select bit (byte mode) |
| wr_byte | output | 1 | Capture was made in byte mode |
| wr_data | output | DW/2 | Captured low data byte |
| wr_drop | output | 1 | One-cycle pulse for a discarded write |

## Verification
If the capture state machine is stuck in its active state, the next write produces no record and no discard within the 4-cycle window. That fault is visible at the ports on the very next write. A wrong edge choice shows as a stale address or data byte in the record, so the stimulus moves the address and data between the two falling edges and between the two rising edges. A fault in the read-enable decode shows within three cycles of a pin change, either as lines driven while a control is high or as the wrong byte lane in byte mode.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    WC_IDLE = 2'd0,
    WC_CAPT = 2'd1,
    WC_SKIP = 2'd2
  } wcap_state_e;

  typedef struct packed {
    logic wide;
    logic we_n;
    logic oe_n;
    logic ce_n;
  } ctrl_t;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pbus_read.sv
module pbus_read #(
  parameter int DW = 16,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          wide_s,
  input  logic          dq_top_s,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] dq_oe
);
  logic          rd_on;
  logic [HW-1:0] lane;

  assign rd_on = !ce_s && !oe_s && we_s;
  assign lane  = dq_top_s ? arr_data[DW-1:HW] : arr_data[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o  <= '0;
      dq_oe <= '0;
    end else if (rd_on) begin
      if (wide_s) begin
        dq_o  <= arr_data;
        dq_oe <= '1;
      end else begin
        dq_o  <= {{HW{1'b0}}, lane};
        dq_oe <= {{HW{1'b0}}, {HW{1'b1}}};
      end
    end else begin
      dq_o  <= '0;
      dq_oe <= '0;
    end
  end

  // R2: a high control releases every line one cycle later
  assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s || oe_s) |=> (dq_oe == '0));

  // R3: byte mode never drives the upper lines
  assert_upper_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_s |=> (dq_oe[DW-1:HW] == '0));

  // R1: write enable low blocks any drive
  assert_we_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !we_s |=> (dq_oe == '0));
endmodule

// File: rtl/pbus_wcap.sv
module pbus_wcap #(
  parameter int AW = 18,
  parameter int DW = 16,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          wide_s,
  input  logic [AW-1:0] addr_s,
  input  logic          dq_top_s,
  input  logic [HW-1:0] dq_lo_s,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_lsb,
  output logic          wr_byte,
  output logic [HW-1:0] wr_data,
  output logic          wr_drop
);
  import pbus_pkg::*;

  wcap_state_e state;
  logic        act, prev_act;

  // a write is in progress while both strobes are low
  assign act = !ce_s && !we_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WC_IDLE;
      prev_act <= 1'b0;
      wr_valid <= 1'b0;
      wr_drop  <= 1'b0;
      wr_addr  <= '0;
      wr_lsb   <= 1'b0;
      wr_byte  <= 1'b0;
      wr_data  <= '0;
    end else begin
      prev_act <= act;
      wr_valid <= 1'b0;
      wr_drop  <= 1'b0;
      unique case (state)
        WC_IDLE: begin
          if (act && !prev_act) begin
            if (!oe_s) begin
              wr_drop <= 1'b1;
              state   <= WC_SKIP;
            end else begin
              wr_addr <= addr_s;
              wr_byte <= !wide_s;
              wr_lsb  <= !wide_s && dq_top_s;
              state   <= WC_CAPT;
            end
          end
        end
        WC_CAPT: begin
          if (!oe_s) begin
            wr_drop <= 1'b1;
            state   <= act ? WC_SKIP : WC_IDLE;
          end else if (!act) begin
            wr_data  <= dq_lo_s;
            wr_valid <= 1'b1;
            state    <= WC_IDLE;
          end
        end
        WC_SKIP: begin
          if (!act) state <= WC_IDLE;
        end
        default: state <= WC_IDLE;
      endcase
    end
  end

  // R11: the strobe lasts a single cycle
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R11: a record and a discard never coincide
  assert_valid_drop_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_drop));

  // R7: a record follows the end of the cycle
  assert_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(ce_s || we_s));

  // R9: a discard follows output enable being low
  assert_drop_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> !$past(oe_s));

  // R8: the byte-select bit is set only in byte mode
  assert_lsb_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_byte || !wr_lsb));
endmodule

// File: rtl/pbus_front.sv
module pbus_front #(
  parameter int AW     = 18,
  parameter int DW     = 16,
  parameter int STAGES = 2,
  localparam int HW    = DW / 2,
  localparam int BW    = AW + HW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_n,
  input  logic          bus_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_dq_i,
  output logic [DW-1:0] bus_dq_o,
  output logic [DW-1:0] bus_dq_oe,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_lsb,
  output logic          wr_byte,
  output logic [HW-1:0] wr_data,
  output logic          wr_drop
);
  import pbus_pkg::*;

  ctrl_t         ctrl_raw, ctrl_s;
  logic [BW-1:0] bus_raw, bus_s;
  logic [AW-1:0] addr_s;
  logic          dq_top_s;
  logic [HW-1:0] dq_lo_s;

  assign ctrl_raw = '{wide: bus_wide, we_n: bus_we_n, oe_n: bus_oe_n, ce_n: bus_ce_n};
  assign bus_raw  = {bus_addr, bus_dq_i[DW-1], bus_dq_i[HW-1:0]};

  pbus_sync #(.W($bits(ctrl_t)), .STAGES(STAGES), .RST_VAL('1)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  pbus_sync #(.W(BW), .STAGES(STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign addr_s   = bus_s[BW-1:HW+1];
  assign dq_top_s = bus_s[HW];
  assign dq_lo_s  = bus_s[HW-1:0];
  assign arr_addr = addr_s;

  pbus_read #(.DW(DW)) u_read (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctrl_s.ce_n), .oe_s(ctrl_s.oe_n), .we_s(ctrl_s.we_n),
    .wide_s(ctrl_s.wide), .dq_top_s(dq_top_s), .arr_data(arr_data),
    .dq_o(bus_dq_o), .dq_oe(bus_dq_oe)
  );

  pbus_wcap #(.AW(AW), .DW(DW)) u_wcap (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctrl_s.ce_n), .oe_s(ctrl_s.oe_n), .we_s(ctrl_s.we_n),
    .wide_s(ctrl_s.wide), .addr_s(addr_s), .dq_top_s(dq_top_s), .dq_lo_s(dq_lo_s),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_byte(wr_byte),
    .wr_data(wr_data), .wr_drop(wr_drop)
  );

  // R2: no line is driven while writes are being captured or dropped
  assert_quiet_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || wr_drop) |-> (bus_dq_oe == '0));
endmodule

// File: tb/pbus_front_tb.sv
module pbus_front_tb;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int HW = DW / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1, bus_wide = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_dq_i = '0;
  logic [DW-1:0] bus_dq_o, bus_dq_oe, arr_data;
  logic [AW-1:0] arr_addr, wr_addr;
  logic          wr_valid, wr_lsb, wr_byte, wr_drop;
  logic [HW-1:0] wr_data;

  int tests = 0, fails = 0, cyc = 0;
  int nval = 0, ndrop = 0, dbl = 0, vcyc = 0;
  logic prev_v = 1'b0;
  logic [AW-1:0] l_addr;
  logic [HW-1:0] l_data;
  logic l_lsb, l_byte;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5AC3 ^ {a[17:16], 14'b0};
  endfunction
  assign arr_data = model(arr_addr);

  pbus_front #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_dq_i(bus_dq_i), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
    .arr_addr(arr_addr), .arr_data(arr_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_byte(wr_byte),
    .wr_data(wr_data), .wr_drop(wr_drop)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_valid) begin
      nval++;
      vcyc   = cyc;
      l_addr = wr_addr; l_data = wr_data; l_lsb = wr_lsb; l_byte = wr_byte;
      if (prev_v) dbl++;
      if (wr_drop) dbl++;
    end
    if (wr_drop) ndrop++;
    prev_v = wr_valid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 reset oe", 32'(bus_dq_oe), 32'h0);
    check("R11 reset valid", 32'(wr_valid), 32'h0);
  endtask

  task automatic t_read_word();
    idle(1);
    bus_wide = 1; bus_we_n = 1; bus_addr = 18'h1234A; bus_ce_n = 0; bus_oe_n = 0;
    idle(6);
    check("R1 word oe", 32'(bus_dq_oe), 32'hFFFF);
    check("R1 word data", 32'(bus_dq_o), 32'(model(18'h1234A)));
    bus_addr = 18'h3F00F; idle(6);
    check("R1 word data b", 32'(bus_dq_o), 32'(model(18'h3F00F)));
    bus_oe_n = 1; idle(6);
    check("R2 oe high", 32'(bus_dq_oe), 32'h0);
    bus_oe_n = 0; bus_ce_n = 1; idle(6);
    check("R2 ce high", 32'(bus_dq_oe), 32'h0);
    bus_oe_n = 1; idle(2);
  endtask

  task automatic t_read_we_low();
    idle(1);
    bus_ce_n = 0; bus_oe_n = 0; bus_we_n = 0; idle(6);
    check("R1 we low no drive", 32'(bus_dq_oe), 32'h0);
    bus_we_n = 1; bus_ce_n = 1; bus_oe_n = 1; idle(6);
  endtask

  task automatic t_read_byte();
    idle(1);
    bus_wide = 0; bus_addr = 18'h00A5C; bus_dq_i = 16'h0000;
    bus_ce_n = 0; bus_oe_n = 0; idle(6);
    check("R3 byte oe", 32'(bus_dq_oe), 32'h00FF);
    check("R3 low lane", 32'(bus_dq_o[HW-1:0]), 32'(model(18'h00A5C) & 16'h00FF));
    bus_dq_i = 16'h8000; idle(6);
    check("R3 high lane", 32'(bus_dq_o[HW-1:0]), 32'(model(18'h00A5C) >> 8));
    bus_ce_n = 1; bus_oe_n = 1; bus_wide = 1; bus_dq_i = 0; idle(6);
  endtask

  task automatic t_write_we();
    int n0 = nval, c0;
    idle(1);
    bus_wide = 1; bus_addr = 18'h2AAAA; bus_dq_i = 16'hFF3C;
    bus_ce_n = 0; idle(3);
    bus_we_n = 0; idle(4);
    bus_we_n = 1; c0 = cyc; idle(6);
    bus_ce_n = 1; idle(6);
    check("R4 one record", 32'(nval - n0), 32'd1);
    check("R4 addr", 32'(l_addr), 32'h2AAAA);
    check("R8 data low byte", 32'(l_data), 32'h3C);
    check("R8 word mode flags", {30'b0, l_byte, l_lsb}, 32'h0);
    check("R12 latency", 32'((vcyc - c0) <= 4), 32'h1);
  endtask

  task automatic t_write_ce_byte();
    int n0 = nval;
    idle(1);
    bus_wide = 0; bus_addr = 18'h00155; bus_dq_i = 16'h8077;
    bus_we_n = 0; idle(3);
    bus_ce_n = 0; idle(4);
    bus_dq_i = 16'h0071; bus_ce_n = 1; idle(5);
    bus_we_n = 1; idle(6);
    check("R5 one record", 32'(nval - n0), 32'd1);
    check("R5 addr", 32'(l_addr), 32'h00155);
    check("R8 byte flags", {30'b0, l_byte, l_lsb}, 32'h3);
    bus_wide = 1; idle(4);
  endtask

  task automatic t_addr_late();
    idle(1);
    bus_wide = 1; bus_addr = 18'h11111; bus_dq_i = 16'h0042;
    bus_we_n = 0; idle(4);
    bus_addr = 18'h22222; idle(4);
    bus_ce_n = 0; idle(4);
    bus_addr = 18'h33333; idle(3);
    bus_we_n = 1; idle(4);
    bus_ce_n = 1; idle(6);
    check("R6 later fall addr", 32'(l_addr), 32'h22222);
  endtask

  task automatic t_data_early();
    int n0 = nval;
    idle(1);
    bus_addr = 18'h00777; bus_dq_i = 16'h00D1;
    bus_ce_n = 0; bus_we_n = 0; idle(4);
    bus_ce_n = 1; idle(4);
    bus_dq_i = 16'h00E2; idle(3);
    bus_we_n = 1; idle(6);
    check("R7 first rise data", 32'(l_data), 32'hD1);
    check("R7 single record", 32'(nval - n0), 32'd1);
  endtask

  task automatic t_drop_start();
    int n0 = nval, d0 = ndrop;
    idle(1);
    bus_oe_n = 0; bus_ce_n = 0; idle(3);
    bus_we_n = 0; idle(4);
    bus_we_n = 1; idle(3);
    bus_ce_n = 1; bus_oe_n = 1; idle(6);
    check("R9 no record", 32'(nval - n0), 32'd0);
    check("R9 one drop", 32'(ndrop - d0), 32'd1);
  endtask

  task automatic t_drop_mid();
    int n0 = nval, d0 = ndrop;
    idle(1);
    bus_ce_n = 0; bus_we_n = 0; idle(4);
    bus_oe_n = 0; idle(4);
    bus_oe_n = 1; idle(2);
    bus_we_n = 1; idle(2);
    bus_ce_n = 1; idle(6);
    check("R10 no record", 32'(nval - n0), 32'd0);
    check("R10 one drop", 32'(ndrop - d0), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    idle(3);
    t_reset();
    t_read_word();
    t_read_we_low();
    t_read_byte();
    t_write_we();
    t_write_ce_byte();
    t_addr_late();
    t_data_early();
    t_drop_start();
    t_drop_mid();
    check("R11 strobe shape", 32'(dbl), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule